// File: doc/BRIEF.md
# Self-Repairing Residue FIR Channel

This block computes one residue channel of a transversal filter in a residue number system. Every sum and product is reduced modulo one small odd integer (31 by default, 5-bit residues), so no carry leaves the channel. The filter is a row of identical tap cells. Each cell talks only to its two neighbours: it passes the delayed sample forward and adds its own product to the partial sum coming from the cell before it. The chain advances once for each accepted sample strobe.

Each cell computes its modular multiply-accumulate twice, by two different reduction paths, and compares the two results on every strobe. A cell that disagrees with itself on four strobes in a row is judged faulty. The chain then routes around that cell. It brings in the one spare cell placed at the tail and moves the coefficients downstream of the fault one slot toward the tail, so the response and the latency do not change. A second persistent fault sets a sticky fatal flag.

Coefficients are shifted in serially while filtering is stalled. A fault-injection input can force a cell's main path to go wrong, so that the detection and repair paths can be exercised.

Top module: `rns_fir_channel`

## Requirements
- R1: `out_res` is always a residue in the range 0 to MOD-1.
- R2: With TAPS = K, count accepted strobes from 0 and let x(n) be the sample of strobe n. After strobe n, `out_res` equals the sum over j of h_j·x(n-K-j), modulo MOD, where samples before the pipeline was flushed count as 0.
- R3: A strobe is accepted when `in_valid` is 1 and `coef_load` is 0. `out_valid` is 1 in the cycle after an accepted strobe, and 0 after any other cycle.
- R4: While `coef_load` is 1, `coef_in` shifts into the tail of the active chain, each value moving one cell toward the head. After K pushes, tap j holds the j-th value pushed, counting from 0. During loading, `in_valid` is ignored, the sample pipeline does not move, and `out_valid` stays 0.
- R5: After an accepted strobe in which an active cell's two paths disagree, that cell's bit in `err_flags` is 1. After a strobe in which they agree, the bit is 0. A 1 on bit i of `flt_inject` makes cell i's main result one less, modulo MOD.
- R6: Up to three consecutive disagreeing strobes in a cell cause no repair. One agreeing strobe restarts that cell's count.
- R7: On the fourth consecutive disagreeing strobe of an active cell, `spare_used` becomes 1 after that edge and stays 1. The cell leaves the chain and the spare joins at the tail. Once the pipeline has been flushed, R2 holds again with the same coefficients and the same K.
- R8: After a repair, the bypassed cell has no effect: its `err_flags` bit stays 0, and faults injected into it do not change `out_res`.
- R9: A persistent fault in an active cell after a repair, or two persistent faults on the same strobe, sets `fatal`, which stays 1.
- R10: After reset, `out_valid`, `out_res`, `err_flags`, `spare_used` and `fatal` are all 0, and all coefficients are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| in_valid | input | 1 | sample strobe |
| in_res | input | RW | input residue |
| coef_load | input | 1 | coefficient shift enable, stalls filtering |
| coef_in | input | RW | serial coefficient residue |
| flt_inject | input | TAPS+1 | per-cell forced fault on the main path |
| out_valid | output | 1 | result strobe |
| out_res | output | RW | output residue |
| err_flags | output | TAPS+1 | per-cell self-check mismatch of the last strobe |
| spare_used | output | 1 | a cell has been replaced by the spare |
| fatal | output | 1 | sticky unrecoverable fault |

## Verification
The result of a sample is due TAPS strobes after its own strobe. It is registered on the edge of that strobe, so the bench drives each strobe at a falling edge and reads `out_valid` and `out_res` at the next falling edge. The bench compares them with a convolution computed from its own copy of the coefficients and its own sample history. The error flags, the repair flag and the fatal flag are all registered on the edge of the strobe that causes them, so they are read at that same next falling edge: the third and fourth fault strobes show the repair flag just before and just after the threshold. After any load or repair, the bench first pushes 2·TAPS zero samples, and only then starts comparing results.

// File: rtl/rns_fir_pkg.sv
package rns_fir_pkg;
  // main path: one combined reduction of acc + x*h
  function automatic int mac_main(input int a, input int x, input int h, input int m);
    return (a + x * h) % m;
  endfunction

  // check path: reduce product first, then fold the sum with one subtract
  function automatic int mac_check(input int a, input int x, input int h, input int m);
    int p;
    int s;
    p = (x * h) % m;
    s = p + a;
    return (s >= m) ? s - m : s;
  endfunction
endpackage

// File: rtl/rns_tap_cell.sv
module rns_tap_cell #(
  parameter int MOD     = 31,
  parameter int RW      = 5,
  parameter int PERSIST = 4,
  localparam int CW     = $clog2(PERSIST + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          active,
  input  logic          fault,
  input  logic          coef_ld,
  input  logic [RW-1:0] coef_d,
  input  logic [RW-1:0] x_in,
  input  logic [RW-1:0] acc_in,
  output logic [RW-1:0] x_out,
  output logic [RW-1:0] acc_out,
  output logic [RW-1:0] coef_q,
  output logic          err_q,
  output logic          persist
);
  import rns_fir_pkg::*;

  logic [RW-1:0] x_a, x_b, acc_r, coef_r;
  logic [RW-1:0] raw_main, sum_main, sum_chk;
  logic [CW-1:0] run_cnt;
  logic          err_r, mism;

  always_comb begin
    raw_main = RW'(mac_main(int'(acc_in), int'(x_in), int'(coef_r), MOD));
    sum_chk  = RW'(mac_check(int'(acc_in), int'(x_in), int'(coef_r), MOD));
    if (fault)
      sum_main = (raw_main == '0) ? RW'(MOD - 1) : raw_main - RW'(1);
    else
      sum_main = raw_main;
    mism    = (sum_main != sum_chk);
    persist = adv & active & mism & (run_cnt == CW'(PERSIST - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_a     <= '0;
      x_b     <= '0;
      acc_r   <= '0;
      coef_r  <= '0;
      err_r   <= 1'b0;
      run_cnt <= '0;
    end else begin
      if (coef_ld) coef_r <= coef_d;
      if (adv) begin
        x_a   <= x_in;
        x_b   <= x_a;
        acc_r <= sum_main;
        err_r <= active & mism;
        if (active & mism) begin
          if (run_cnt < CW'(PERSIST - 1)) run_cnt <= run_cnt + CW'(1);
        end else begin
          run_cnt <= '0;
        end
      end
    end
  end

  assign x_out   = x_b;
  assign acc_out = acc_r;
  assign coef_q  = coef_r;
  assign err_q   = err_r;
endmodule

// File: rtl/rns_repair_ctrl.sv
module rns_repair_ctrl #(
  parameter int NC = 9,
  localparam int IW = $clog2(NC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NC-1:0] persist,
  output logic          bad_vld,
  output logic [IW-1:0] bad_idx,
  output logic          repair_go,
  output logic [IW-1:0] pick_idx,
  output logic          fatal_q
);
  logic any_p, multi_p;

  always_comb begin
    pick_idx = '0;
    for (int i = NC - 1; i >= 0; i--)
      if (persist[i]) pick_idx = IW'(i);
    any_p     = |persist;
    multi_p   = (persist & (persist - NC'(1))) != '0;
    repair_go = any_p & ~bad_vld;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bad_vld <= 1'b0;
      bad_idx <= '0;
      fatal_q <= 1'b0;
    end else begin
      if (repair_go) begin
        bad_vld <= 1'b1;
        bad_idx <= pick_idx;
      end
      fatal_q <= fatal_q | (any_p & bad_vld) | multi_p;
    end
  end
endmodule

// File: rtl/rns_fir_channel.sv
module rns_fir_channel #(
  parameter int MOD     = 31,
  parameter int RW      = $clog2(MOD),
  parameter int TAPS    = 8,
  parameter int PERSIST = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [RW-1:0] in_res,
  input  logic          coef_load,
  input  logic [RW-1:0] coef_in,
  input  logic [TAPS:0] flt_inject,
  output logic          out_valid,
  output logic [RW-1:0] out_res,
  output logic [TAPS:0] err_flags,
  output logic          spare_used,
  output logic          fatal
);
  localparam int NC = TAPS + 1;
  localparam int IW = $clog2(NC);

  logic          adv;
  logic [RW-1:0] xo [NC];
  logic [RW-1:0] ao [NC];
  logic [RW-1:0] co [NC];
  logic [NC-1:0] persist, err_v;
  logic          bad_vld, repair_go;
  logic [IW-1:0] bad_idx, pick_idx;
  logic          unused_tail;

  assign adv         = in_valid & ~coef_load;
  assign unused_tail = ^xo[NC-1];

  for (genvar p = 0; p < NC; p++) begin : g_cell
    logic [RW-1:0] x_src, acc_src, ld_src, coef_d;
    logic          active, coef_ld, rep_ld;

    // a cell is active unless it is bypassed, or it is the idle spare
    if (p == NC - 1) begin : g_act_spare
      assign active = bad_vld;
    end else begin : g_act_main
      assign active = ~(bad_vld & (bad_idx == IW'(p)));
    end

    // upstream neighbour, skipping a bypassed cell
    if (p == 0) begin : g_up0
      assign x_src   = in_res;
      assign acc_src = '0;
    end else if (p == 1) begin : g_up1
      assign x_src   = (bad_vld && bad_idx == '0) ? in_res : xo[0];
      assign acc_src = (bad_vld && bad_idx == '0) ? '0     : ao[0];
    end else begin : g_upn
      assign x_src   = (bad_vld && bad_idx == IW'(p - 1)) ? xo[p-2] : xo[p-1];
      assign acc_src = (bad_vld && bad_idx == IW'(p - 1)) ? ao[p-2] : ao[p-1];
    end

    // serial coefficient source: next active cell, or the port at the tail
    if (p == NC - 1) begin : g_ld_spare
      assign ld_src = coef_in;
    end else if (p == NC - 2) begin : g_ld_last
      assign ld_src = bad_vld ? co[p+1] : coef_in;
    end else begin : g_ld_mid
      assign ld_src = (bad_vld && bad_idx == IW'(p + 1)) ? co[p+2] : co[p+1];
    end

    // on repair, cells downstream of the fault take their left neighbour's coefficient
    if (p == 0) begin : g_rep0
      assign rep_ld = 1'b0;
      assign coef_d = ld_src;
    end else begin : g_repn
      assign rep_ld = repair_go & (pick_idx < IW'(p));
      assign coef_d = coef_load ? ld_src : co[p-1];
    end

    assign coef_ld = (coef_load & active) | rep_ld;

    rns_tap_cell #(.MOD(MOD), .RW(RW), .PERSIST(PERSIST)) cell_i (
      .clk(clk), .rst(rst), .adv(adv), .active(active), .fault(flt_inject[p]),
      .coef_ld(coef_ld), .coef_d(coef_d), .x_in(x_src), .acc_in(acc_src),
      .x_out(xo[p]), .acc_out(ao[p]), .coef_q(co[p]),
      .err_q(err_v[p]), .persist(persist[p])
    );
  end

  rns_repair_ctrl #(.NC(NC)) ctrl_i (
    .clk(clk), .rst(rst), .persist(persist),
    .bad_vld(bad_vld), .bad_idx(bad_idx), .repair_go(repair_go),
    .pick_idx(pick_idx), .fatal_q(fatal)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_res   <= '0;
    end else begin
      out_valid <= adv;
      if (adv) out_res <= bad_vld ? ao[NC-1] : ao[NC-2];
    end
  end

  assign err_flags  = err_v;
  assign spare_used = bad_vld;
endmodule

// File: rtl/rns_fir_channel_chk.sv
module rns_fir_channel_chk #(
  parameter int MOD  = 31,
  parameter int RW   = 5,
  parameter int TAPS = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          coef_load,
  input logic          out_valid,
  input logic [RW-1:0] out_res,
  input logic [TAPS:0] err_flags,
  input logic          spare_used,
  input logic          fatal
);
  // R1
  res_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(out_res) < MOD);
  // R3
  strobe_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !coef_load) |=> out_valid);
  // R3
  idle_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && !coef_load) |=> !out_valid);
  // R4
  load_hold_chk: assert property (@(posedge clk) disable iff (rst)
    coef_load |=> $stable(out_res));
  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && !coef_load) |=> $stable(err_flags));
  // R7
  spare_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    spare_used |=> spare_used);
  // R9
  fatal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    fatal |=> fatal);
endmodule

bind rns_fir_channel rns_fir_channel_chk #(.MOD(MOD), .RW(RW), .TAPS(TAPS)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .coef_load(coef_load),
  .out_valid(out_valid), .out_res(out_res), .err_flags(err_flags),
  .spare_used(spare_used), .fatal(fatal)
);

// File: tb/rns_fir_channel_tb_top.sv
`timescale 1ns/1ps
module rns_fir_channel_tb_top;
  localparam int MOD  = 31;
  localparam int RW   = 5;
  localparam int TAPS = 8;
  localparam int NC   = TAPS + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [RW-1:0] in_res = '0;
  logic          coef_load = 1'b0;
  logic [RW-1:0] coef_in = '0;
  logic [NC-1:0] flt_inject = '0;
  logic          out_valid;
  logic [RW-1:0] out_res;
  logic [NC-1:0] err_flags;
  logic          spare_used, fatal;

  int checks = 0;
  int errors = 0;
  int h [TAPS] = '{3, 0, 30, 17, 1, 22, 9, 14};
  int xs [256];
  int n_s = 0;

  always #2 clk = ~clk;

  rns_fir_channel #(.MOD(MOD), .RW(RW), .TAPS(TAPS), .PERSIST(4)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_res(in_res),
    .coef_load(coef_load), .coef_in(coef_in), .flt_inject(flt_inject),
    .out_valid(out_valid), .out_res(out_res), .err_flags(err_flags),
    .spare_used(spare_used), .fatal(fatal)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_out(input int n);
    int acc = 0;
    for (int j = 0; j < TAPS; j++)
      if (n - TAPS - j >= 0) acc += h[j] * xs[n - TAPS - j];
    return acc % MOD;
  endfunction

  // one accepted strobe: drive at a falling edge, read at the next one
  task automatic strobe(input int x, input logic [NC-1:0] f, input bit cmp);
    in_valid = 1'b1; in_res = RW'(x); flt_inject = f;
    @(negedge clk);
    in_valid = 1'b0;
    if (cmp) begin
      xs[n_s] = x;
      chk("R3 out_valid", int'(out_valid), 1);
      chk("R1 range", int'(out_res) < MOD, 1);
      chk("R2 result", int'(out_res), model_out(n_s));
      n_s++;
    end
  endtask

  task automatic flush(input logic [NC-1:0] f);
    for (int i = 0; i < 2 * TAPS; i++) strobe(0, f, 1'b0);
    n_s = 0;
  endtask

  task automatic t_reset;
    chk("R10 out_valid", int'(out_valid), 0);
    chk("R10 out_res", int'(out_res), 0);
    chk("R10 err_flags", int'(err_flags), 0);
    chk("R10 spare_used", int'(spare_used), 0);
    chk("R10 fatal", int'(fatal), 0);
  endtask

  task automatic t_load_impulse;
    // in_valid held high with a nonzero sample during load must be ignored
    for (int k = 0; k < TAPS; k++) begin
      coef_load = 1'b1; coef_in = RW'(h[k]); in_valid = 1'b1; in_res = 7;
      @(negedge clk);
      chk("R4 no out_valid while loading", int'(out_valid), 0);
    end
    coef_load = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    chk("R3 idle cycle", int'(out_valid), 0);
    n_s = 0;
    strobe(1, '0, 1'b1);
    for (int i = 0; i < 2 * TAPS; i++) strobe(0, '0, 1'b1);
  endtask

  task automatic t_random(input int cnt);
    for (int i = 0; i < cnt; i++) strobe($urandom_range(0, MOD - 1), flt_inject, 1'b1);
  endtask

  task automatic t_transient;
    logic [NC-1:0] f3 = NC'(1) << 3;
    flush('0);
    for (int i = 0; i < 3; i++) begin
      strobe(0, f3, 1'b0);
      chk("R5 flag on mismatch", int'(err_flags[3]), 1);
    end
    strobe(0, '0, 1'b0);
    chk("R5 flag clears on match", int'(err_flags), 0);
    for (int i = 0; i < 3; i++) strobe(0, f3, 1'b0);
    chk("R6 no repair below threshold", int'(spare_used), 0);
    strobe(0, '0, 1'b0);
    chk("R6 still no repair", int'(spare_used), 0);
  endtask

  task automatic t_repair;
    logic [NC-1:0] f2 = NC'(1) << 2;
    for (int i = 0; i < 3; i++) strobe(0, f2, 1'b0);
    chk("R7 not yet repaired", int'(spare_used), 0);
    strobe(0, f2, 1'b0);
    chk("R7 repaired on fourth", int'(spare_used), 1);
    chk("R9 single fault not fatal", int'(fatal), 0);
    flush(f2);
    chk("R8 bypassed flag quiet", int'(err_flags), 0);
    strobe(1, f2, 1'b1);
    for (int i = 0; i < 2 * TAPS; i++) strobe(0, f2, 1'b1);
    t_random(20);
    chk("R8 bypassed flag still quiet", int'(err_flags), 0);
  endtask

  task automatic t_fatal;
    logic [NC-1:0] f25 = (NC'(1) << 2) | (NC'(1) << 5);
    for (int i = 0; i < 3; i++) strobe(0, f25, 1'b0);
    chk("R9 not fatal before fourth", int'(fatal), 0);
    strobe(0, f25, 1'b0);
    chk("R9 fatal on second fault", int'(fatal), 1);
    for (int i = 0; i < 3; i++) strobe(0, '0, 1'b0);
    chk("R9 fatal sticky", int'(fatal), 1);
    chk("R7 spare sticky", int'(spare_used), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load_impulse();
    t_random(40);
    t_transient();
    t_repair();
    t_fatal();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule